// File: doc/BRIEF.md
# Raster Scan Address Generator with Tear-Free Register Latching

This block produces the running display-memory address and the horizontal pixel shift for one raster controller. A host programs six byte-wide registers through a small write port: two bytes of frame start address, a line pitch in bytes, a ten-bit split-screen line number spread over two bytes, and a four-bit pixel pan value. A separate raster timing generator drives four strobes: a character-clock enable, an end-of-line pulse, a start-of-vertical-sync pulse and a display-enable level.

The host registers are never used directly by the scan. The start address is copied into the address pointer only on the start-of-vertical-sync pulse, so a host that rewrites both bytes at any point of a frame cannot tear that frame. The pan value is copied into the output shift register only on the end-of-line pulse, so it changes exactly between lines. Within a line the pointer steps by one per enabled character; at each line end it jumps to the previous line's base plus the pitch. On the line whose number equals the split value the pointer and line base restart at zero, and following lines step onward from zero until the next vertical sync.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is low, and after it is released without register writes, `mem_addr` and `pix_shift` are 0 and all host registers hold 0, so a vertical sync loads address 0.
- R2: One clock after an edge on which `vsync_start` is high, `mem_addr` equals {start high byte, start low byte} as held before that edge.
- R3: On an edge with `char_en` and `disp_en` both high (and no `line_end` or `vsync_start`), `mem_addr` increases by 1 modulo 2^16; if either is low it holds.
- R4: On an edge with `line_end` high (no `vsync_start`, no split match), `mem_addr` and the line base become the previous line base plus the pitch register (zero-extended), modulo 2^16.
- R5: A line counter counts `line_end` pulses; on the `line_end` that brings it to the split value, `mem_addr` and the line base become 0, and later lines of that frame advance by the pitch from 0.
- R6: One clock after a `line_end` edge, `pix_shift` equals the pan register; a host write to the pan register alone leaves `pix_shift` unchanged.
- R7: Host writes to the start address bytes do not change `mem_addr`; a start write on the same edge as `vsync_start` is not seen by that sync, only by the next.
- R8: Priority on one edge: `vsync_start` over `line_end` over the character step.
- R9: Register select codes on `reg_sel` when `reg_we` is high: 0 start high byte, 1 start low byte, 2 pitch, 3 split bits [7:0], 4 split bits [9:8] from `reg_wdata[1:0]`, 5 pan from `reg_wdata[3:0]`; codes 6 and 7 change nothing.
- R10: The 10-bit line counter returns to 0 on every `vsync_start`, so a split match counts lines from the most recent sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select code |
| reg_wdata | input | 8 | Host write data |
| char_en | input | 1 | Character clock enable |
| line_end | input | 1 | End-of-scan-line pulse |
| vsync_start | input | 1 | Start-of-vertical-sync pulse |
| disp_en | input | 1 | Active display level |
| mem_addr | output | 16 | Current display memory address |
| pix_shift | output | 4 | Pixel shift in effect for the current line |

## Verification
The two functions that can fall on the same edge are a host write to a start-address byte and the frame-start load on `vsync_start`; the bench drives both in one cycle and expects the pointer to take the old address, then the new one at the following sync. It also forces `line_end` together with `vsync_start`, and `line_end` together with an enabled character on the split line, judging from the address seen one clock later which event won.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int ADDR_W_DEF = 16;
  localparam int OFF_W_DEF  = 8;
  localparam int LINE_W_DEF = 10;
  localparam int PAN_W_DEF  = 4;
  localparam int SEL_W      = 3;
  localparam int DATA_W     = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_START_HI = 3'd0,
    SEL_START_LO = 3'd1,
    SEL_PITCH    = 3'd2,
    SEL_SPLIT_LO = 3'd3,
    SEL_SPLIT_HI = 3'd4,
    SEL_PAN      = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/host_regs.sv
module host_regs
  import scan_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int LINE_W = LINE_W_DEF,
  parameter int PAN_W  = PAN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [OFF_W-1:0]  pitch,
  output logic [LINE_W-1:0] split_line,
  output logic [PAN_W-1:0]  pan_val
);

  localparam int HI_W       = ADDR_W - DATA_W;
  localparam int SPLIT_HI_W = LINE_W - DATA_W;

  logic [HI_W-1:0]       start_hi_q;
  logic [DATA_W-1:0]     start_lo_q;
  logic [OFF_W-1:0]      pitch_q;
  logic [DATA_W-1:0]     split_lo_q;
  logic [SPLIT_HI_W-1:0] split_hi_q;
  logic [PAN_W-1:0]      pan_q;

  // one-hot decode of the select code; unused codes decode to nothing
  logic wr_start_hi, wr_start_lo, wr_pitch, wr_split_lo, wr_split_hi, wr_pan;

  always_comb begin
    wr_start_hi = we && (sel == SEL_START_HI);
    wr_start_lo = we && (sel == SEL_START_LO);
    wr_pitch    = we && (sel == SEL_PITCH);
    wr_split_lo = we && (sel == SEL_SPLIT_LO);
    wr_split_hi = we && (sel == SEL_SPLIT_HI);
    wr_pan      = we && (sel == SEL_PAN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_hi_q <= '0;
      start_lo_q <= '0;
      pitch_q    <= '0;
      split_lo_q <= '0;
      split_hi_q <= '0;
      pan_q      <= '0;
    end else begin
      if (wr_start_hi) start_hi_q <= wdata[HI_W-1:0];
      if (wr_start_lo) start_lo_q <= wdata;
      if (wr_pitch)    pitch_q    <= wdata[OFF_W-1:0];
      if (wr_split_lo) split_lo_q <= wdata;
      if (wr_split_hi) split_hi_q <= wdata[SPLIT_HI_W-1:0];
      if (wr_pan)      pan_q      <= wdata[PAN_W-1:0];
    end
  end

  assign start_addr = {start_hi_q, start_lo_q};
  assign pitch      = pitch_q;
  assign split_line = {split_hi_q, split_lo_q};
  assign pan_val    = pan_q;

endmodule

// File: rtl/line_tracker.sv
module line_tracker
  import scan_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_start,
  input  logic              line_end,
  input  logic [LINE_W-1:0] split_line,
  output logic              split_hit
);

  logic [LINE_W-1:0] line_cnt_q;
  logic [LINE_W-1:0] line_cnt_nx;

  function automatic logic [LINE_W-1:0] bump_line(input logic [LINE_W-1:0] cur);
    return LINE_W'(cur + 1'b1);
  endfunction

  assign line_cnt_nx = bump_line(line_cnt_q);
  // the split event fires on the line end that enters the split line
  assign split_hit   = line_end && !vsync_start && (line_cnt_nx == split_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_cnt_q <= '0;
    else if (vsync_start) line_cnt_q <= '0;
    else if (line_end)    line_cnt_q <= line_cnt_nx;
  end

endmodule

// File: rtl/addr_pointer.sv
module addr_pointer
  import scan_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFF_W  = OFF_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_start,
  input  logic              line_end,
  input  logic              char_step,
  input  logic              split_hit,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFF_W-1:0]  pitch,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] line_base
);

  logic [ADDR_W-1:0] ptr_q, base_q;
  logic [ADDR_W-1:0] ptr_d, base_d;

  function automatic logic [ADDR_W-1:0] next_line_addr(
    input logic [ADDR_W-1:0] base,
    input logic [OFF_W-1:0]  step
  );
    return ADDR_W'(base + ADDR_W'(step));
  endfunction

  function automatic logic [ADDR_W-1:0] next_char_addr(input logic [ADDR_W-1:0] cur);
    return ADDR_W'(cur + 1'b1);
  endfunction

  always_comb begin
    ptr_d  = ptr_q;
    base_d = base_q;
    if (vsync_start) begin
      ptr_d  = start_addr;
      base_d = start_addr;
    end else if (line_end) begin
      if (split_hit) begin
        ptr_d  = '0;
        base_d = '0;
      end else begin
        ptr_d  = next_line_addr(base_q, pitch);
        base_d = next_line_addr(base_q, pitch);
      end
    end else if (char_step) begin
      ptr_d = next_char_addr(ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      base_q <= base_d;
    end
  end

  assign mem_addr  = ptr_q;
  assign line_base = base_q;

endmodule

// File: rtl/pan_latch.sv
module pan_latch
  import scan_pkg::*;
#(
  parameter int PAN_W = PAN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic [PAN_W-1:0] pan_val,
  output logic [PAN_W-1:0] pix_shift
);

  logic [PAN_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (line_end) shift_q <= pan_val;
  end

  assign pix_shift = shift_q;

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFF_W  = OFF_W_DEF,
  parameter int LINE_W = LINE_W_DEF,
  parameter int PAN_W  = PAN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              char_en,
  input  logic              line_end,
  input  logic              vsync_start,
  input  logic              disp_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PAN_W-1:0]  pix_shift
);

  // named internal events, brought out for the checker
  logic [ADDR_W-1:0] start_addr_w;
  logic [OFF_W-1:0]  pitch_w;
  logic [LINE_W-1:0] split_line_w;
  logic [PAN_W-1:0]  pan_val_w;
  logic [ADDR_W-1:0] line_base_w;
  logic              split_hit_w;
  logic              char_step_w;

  assign char_step_w = char_en && disp_en;

  host_regs #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_W(LINE_W), .PAN_W(PAN_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .start_addr (start_addr_w),
    .pitch      (pitch_w),
    .split_line (split_line_w),
    .pan_val    (pan_val_w)
  );

  line_tracker #(.LINE_W(LINE_W)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_start (vsync_start),
    .line_end    (line_end),
    .split_line  (split_line_w),
    .split_hit   (split_hit_w)
  );

  addr_pointer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_start (vsync_start),
    .line_end    (line_end),
    .char_step   (char_step_w),
    .split_hit   (split_hit_w),
    .start_addr  (start_addr_w),
    .pitch       (pitch_w),
    .mem_addr    (mem_addr),
    .line_base   (line_base_w)
  );

  pan_latch #(.PAN_W(PAN_W)) u_pan (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .pan_val   (pan_val_w),
    .pix_shift (pix_shift)
  );

endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int PAN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_start,
  input logic              line_end,
  input logic              char_step,
  input logic              split_hit,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PAN_W-1:0]  pix_shift,
  input logic [ADDR_W-1:0] start_addr,
  input logic [OFF_W-1:0]  pitch,
  input logic [PAN_W-1:0]  pan_val,
  input logic [ADDR_W-1:0] line_base
);

  assert_vsync_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_start |=> mem_addr == $past(start_addr));

  assert_char_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_step && !line_end && !vsync_start) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_step && !line_end && !vsync_start) |=> $stable(mem_addr));

  assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !vsync_start && !split_hit) |=>
      mem_addr == ADDR_W'($past(line_base) + ADDR_W'($past(pitch))));

  assert_split_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    split_hit |=> (mem_addr == '0) && (line_base == '0));

  assert_pan_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> pix_shift == $past(pan_val));

  assert_pan_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(pix_shift));

  assert_sync_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_start && line_end) |=> line_base == $past(start_addr));

endmodule

bind scan_addr_gen scan_addr_gen_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAN_W(PAN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vsync_start (vsync_start),
  .line_end    (line_end),
  .char_step   (char_step_w),
  .split_hit   (split_hit_w),
  .mem_addr    (mem_addr),
  .pix_shift   (pix_shift),
  .start_addr  (start_addr_w),
  .pitch       (pitch_w),
  .pan_val     (pan_val_w),
  .line_base   (line_base_w)
);

// File: tb/scan_addr_gen_test.sv
module scan_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        char_en = 1'b0;
  logic        line_end = 1'b0;
  logic        vsync_start = 1'b0;
  logic        disp_en = 1'b0;
  logic [15:0] mem_addr;
  logic [3:0]  pix_shift;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  scan_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .char_en(char_en), .line_end(line_end),
    .vsync_start(vsync_start), .disp_en(disp_en),
    .mem_addr(mem_addr), .pix_shift(pix_shift)
  );

  // {vs,le,ce,de}, expected pix_shift, expected mem_addr
  // registers: start 0x1234, pitch 0x50, split line 3, pan 5
  localparam logic [23:0] VEC [12] = '{
    24'h801234, 24'h301235, 24'h301236, 24'h201236,
    24'h451284, 24'h351285, 24'h4512D4, 24'h750000,
    24'h350001, 24'h450050, 24'h150050, 24'hC51234
  };

  task automatic check_addr(input string req, input logic [15:0] exp);
    checks++;
    if (mem_addr !== exp) begin
      errors++;
      $display("FAIL %s mem_addr actual %h expected %h", req, mem_addr, exp);
    end
  endtask

  task automatic check_shift(input string req, input logic [3:0] exp);
    checks++;
    if (pix_shift !== exp) begin
      errors++;
      $display("FAIL %s pix_shift actual %h expected %h", req, pix_shift, exp);
    end
  endtask

  task automatic clear_in();
    reg_we = 1'b0; vsync_start = 1'b0; line_end = 1'b0;
    char_en = 1'b0; disp_en = 1'b0;
  endtask

  task automatic tick(input logic vs, input logic le, input logic ce, input logic de);
    vsync_start = vs; line_end = le; char_en = ce; disp_en = de;
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    clear_in();
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_addr("R1 in reset", 16'h0000);
    check_shift("R1 in reset", 4'h0);
    rst_n = 1'b1;
    tick(1, 0, 0, 0);
    check_addr("R1 sync after reset", 16'h0000);

    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h50);
    wr(3'd3, 8'h03); wr(3'd4, 8'h00); wr(3'd5, 8'h05);
    check_addr("R7 start write no effect", 16'h0000);
    check_shift("R6 pan write no effect", 4'h0);

    for (int i = 0; i < 12; i++) begin
      tick(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20]);
      checks++;
      if (mem_addr !== VEC[i][15:0] || pix_shift !== VEC[i][19:16]) begin
        errors++;
        $display("FAIL table step %0d (R2 R3 R4 R5 R8) actual %h/%h expected %h/%h",
                 i, mem_addr, pix_shift, VEC[i][15:0], VEC[i][19:16]);
      end
    end

    // R7: writes mid-frame, and a write on the sync edge itself
    wr(3'd0, 8'hAB); wr(3'd1, 8'hCD);
    check_addr("R7 mid-frame write", 16'h1234);
    tick(1, 0, 0, 0);
    check_addr("R7 next sync", 16'hABCD);
    reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 8'h11;
    tick(1, 0, 0, 0);
    check_addr("R7 same-edge write", 16'hABCD);
    tick(1, 0, 0, 0);
    check_addr("R7 following sync", 16'hAB11);

    // R6 pan timing and field
    wr(3'd5, 8'h09);
    check_shift("R6 before line end", 4'h5);
    tick(0, 1, 0, 0);
    check_shift("R6 at line end", 4'h9);
    wr(3'd5, 8'h3C);
    tick(0, 0, 1, 1);
    check_shift("R6 held within line", 4'h9);
    tick(0, 1, 0, 0);
    check_shift("R6 low nibble", 4'hC);

    // R4 wrap on line step, R3 wrap on char step
    wr(3'd0, 8'hFF); wr(3'd1, 8'hF0); wr(3'd2, 8'h20);
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 0);
    check_addr("R4 line wrap", 16'h0010);
    wr(3'd1, 8'hFF);
    tick(1, 0, 0, 0);
    tick(0, 0, 1, 1);
    check_addr("R3 char wrap", 16'h0000);

    // R10 line counter restarts on sync
    wr(3'd0, 8'h04); wr(3'd1, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'h02);
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 0);
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 0);
    check_addr("R10 line 1 after resync", 16'h0410);
    tick(0, 1, 0, 0);
    check_addr("R10 split at line 2", 16'h0000);

    // R9 unused codes change nothing
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    tick(1, 0, 0, 0);
    check_addr("R9 unused codes start", 16'h0400);
    tick(0, 1, 0, 0);
    check_addr("R9 unused codes pitch", 16'h0410);
    check_shift("R9 unused codes pan", 4'hC);

    // R5 / R9 split high bits: split = 0x102 via hi byte 0xFD
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    wr(3'd3, 8'h02); wr(3'd4, 8'hFD);
    tick(1, 0, 0, 0);
    for (int n = 0; n < 257; n++) tick(0, 1, 0, 0);
    check_addr("R9 split high bits line 257", 16'h0201);
    tick(0, 1, 0, 0);
    check_addr("R5 split at line 258", 16'h0000);
    tick(0, 1, 0, 0);
    check_addr("R5 step from zero", 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule